// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This unit holds the 32-bit control and status word of a floating-point unit. The processor reaches it through a small index/data port that offers four overlapping views of the same storage. One view carries only the condition codes. One carries only the exception cause and the sticky flags. One carries the trap enables, the rounding mode and the flush-to-zero control. The last is the whole word. Index 0 returns a fixed implementation and revision constant.

Reads are combinational from the index. Writes take effect at the next clock edge. The rounding mode and the flush-to-zero control are driven out to the arithmetic datapath. After each operation the datapath pulses a completion strobe with a status vector. The unit then replaces the cause field, accumulates the sticky flags and raises a one-cycle trap request when an enabled or unimplemented exception occurred.

Word layout:
- bits 1:0 hold the rounding mode.
- bits 6:2 hold the flags.
- bits 11:7 hold the enables.
- bits 17:12 hold the cause.
- bit 23 holds condition code 0.
- bit 24 holds flush-to-zero.
- bits 31:25 hold condition codes 1 to 7.
- bits 22:18 are reserved and read as zero.

Inside the flag, enable and cause fields, the exception bit order from bit 0 upward is: inexact, underflow, overflow, divide-by-zero, invalid. The cause field has a sixth bit, unimplemented, at its bit 5.

Top module: `fp_ctrl_reg_unit`

## Requirements
- R1: After reset the whole word is zero, trapReq is low, and a full-view read (index 0x1F) returns 0.
- R2: Index 0 reads the IMPL_REV parameter. A write to index 0 leaves the word unchanged.
- R3: Reading index 0x19 returns condition code 0 (word bit 23) at bit 0 and condition codes 1–7 (word bits 31:25) at bits 7:1. All other bits read as zero.
- R4: Writing index 0x19 with v sets word bit 23 to v[0] and word bits 31:25 to v[7:1]. Every other word bit, flush-to-zero included, keeps its value.
- R5: Index 0x1A reads the word masked to bits 17:12 and 6:2. A write replaces exactly those bits with the same bits of the write data.
- R6: Index 0x1C reads the word masked to bits 11:7 and 1:0. Bit 2 of the read data is also set when flush-to-zero (word bit 24) is set.
- R7: A write to index 0x1C keeps the condition codes, cause and flags. It replaces bits 11:7 and 1:0 from the data, and it sets flush-to-zero to data bit 2 OR data bit 24.
- R8: A write to index 0x1F stores the data with bits 22:18 forced to zero. Those bits stay zero at all times.
- R9: On opDone the cause field is overwritten from opStatus. The status vector holds NUM_INVALID invalid-kind bits at its bottom, then divide-by-zero, overflow, underflow, inexact and unimplemented in ascending order. Any invalid kind sets cause bit 4, divide-by-zero bit 3, overflow bit 2, underflow bit 1, inexact bit 0 and unimplemented bit 5. An empty status clears the cause.
- R10: On opDone the flags OR in cause bits 4:0. The unimplemented bit never reaches the flags, and flags are never cleared by an operation.
- R11: trapReq is high in the cycle after an opDone exactly when (new cause bits 4:0 AND enables) is nonzero or the new cause has its unimplemented bit set, whatever the enables. It is low in every cycle that does not follow an opDone.
- R12: roundMode always equals word bits 1:0 (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward −infinity), and flushZero equals word bit 24.
- R13: Indices other than 0x00, 0x19, 0x1A, 0x1C and 0x1F read as zero, and writes to them leave the word unchanged.
- R14: When a write and opDone fall in the same cycle, the operation update acts on the word as already modified by the write. Its trap test uses the enables after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| index | input | 5 | View select for read and write |
| writeData | input | 32 | Data for a view write |
| writeEn | input | 1 | Write strobe for the selected view |
| readData | output | 32 | Combinational read of the selected view |
| opDone | input | 1 | Arithmetic operation completed this cycle |
| opStatus | input | NUM_INVALID+5 | Exception status of the completed operation |
| trapReq | output | 1 | One-cycle floating-point trap request |
| roundMode | output | 2 | Rounding mode to the datapath |
| flushZero | output | 1 | Flush-to-zero control to the datapath |

## Verification
The bench builds the unit with its defaults: eight invalid-kind status inputs and the default revision constant. With eight kinds, each invalid bit can be driven alone to show that every one of them reaches the single invalid cause bit. Random status vectors, enables and same-cycle writes, checked against a reference word kept in the bench, reach the trap decision for every cause and enable combination. They also cover the interplay between a view write and an operation landing in the same cycle.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

  localparam int WORD_W  = 32;
  localparam int INDEX_W = 5;

  // field geometry; alias views decode these positions
  localparam int RM_LSB      = 0;
  localparam int RM_W        = 2;
  localparam int EXC_W       = 5;
  localparam int CAUSE_W     = EXC_W + 1;
  localparam int FLAG_LSB    = 2;
  localparam int ENA_LSB     = 7;
  localparam int CAUSE_LSB   = 12;
  localparam int RSV_LSB     = CAUSE_LSB + CAUSE_W;
  localparam int CC0_BIT     = 23;
  localparam int RSV_W       = CC0_BIT - RSV_LSB;
  localparam int FTZ_BIT     = 24;
  localparam int CCHI_LSB    = 25;
  localparam int CCHI_W      = WORD_W - CCHI_LSB;
  localparam int CC_VIEW_W   = CCHI_W + 1;
  localparam int ENA_FTZ_ALT = 2;

  // bit order inside the flag / enable / cause fields
  localparam int CB_INEXACT  = 0;
  localparam int CB_UNDER    = 1;
  localparam int CB_OVER     = 2;
  localparam int CB_DIVZ     = 3;
  localparam int CB_INVALID  = 4;
  localparam int CB_UNIMPL   = 5;

  localparam logic [WORD_W-1:0] RM_MASK    = WORD_W'(((1 << RM_W) - 1) << RM_LSB);
  localparam logic [WORD_W-1:0] FLAG_MASK  = WORD_W'(((1 << EXC_W) - 1) << FLAG_LSB);
  localparam logic [WORD_W-1:0] ENA_MASK   = WORD_W'(((1 << EXC_W) - 1) << ENA_LSB);
  localparam logic [WORD_W-1:0] CAUSE_MASK = WORD_W'(((1 << CAUSE_W) - 1) << CAUSE_LSB);
  localparam logic [WORD_W-1:0] RSV_MASK   = WORD_W'(((1 << RSV_W) - 1) << RSV_LSB);
  localparam logic [WORD_W-1:0] FTZ_MASK   = WORD_W'(1) << FTZ_BIT;
  localparam logic [WORD_W-1:0] CC_MASK    = (WORD_W'(1) << CC0_BIT)
                                           | WORD_W'(((64'd1 << CCHI_W) - 1) << CCHI_LSB);
  localparam logic [WORD_W-1:0] EXC_VIEW_MASK = CAUSE_MASK | FLAG_MASK;
  localparam logic [WORD_W-1:0] ENA_VIEW_MASK = ENA_MASK | RM_MASK;
  localparam logic [WORD_W-1:0] ENA_KEEP_MASK = CC_MASK | CAUSE_MASK | FLAG_MASK;

  localparam logic [INDEX_W-1:0] IDX_ID   = 5'h00;
  localparam logic [INDEX_W-1:0] IDX_CC   = 5'h19;
  localparam logic [INDEX_W-1:0] IDX_EXC  = 5'h1A;
  localparam logic [INDEX_W-1:0] IDX_ENA  = 5'h1C;
  localparam logic [INDEX_W-1:0] IDX_FULL = 5'h1F;

  typedef enum logic [2:0] {
    VIEW_NONE,
    VIEW_ID,
    VIEW_CC,
    VIEW_EXC,
    VIEW_ENA,
    VIEW_FULL
  } viewSel_t;

  typedef struct packed {
    logic     wrCc;
    logic     wrExc;
    logic     wrEna;
    logic     wrFull;
    viewSel_t rdView;
  } ctrlStrobes_t;

endpackage

// File: rtl/fpcsr_ctrl.sv
module fpcsr_ctrl
  import fpcsr_pkg::*;
(
  input  logic [INDEX_W-1:0] index,
  input  logic               writeEn,
  output ctrlStrobes_t       strobes
);

  always_comb begin
    strobes.wrCc   = 1'b0;
    strobes.wrExc  = 1'b0;
    strobes.wrEna  = 1'b0;
    strobes.wrFull = 1'b0;
    strobes.rdView = VIEW_NONE;
    unique case (index)
      IDX_ID:   strobes.rdView = VIEW_ID;
      IDX_CC: begin
        strobes.rdView = VIEW_CC;
        strobes.wrCc   = writeEn;
      end
      IDX_EXC: begin
        strobes.rdView = VIEW_EXC;
        strobes.wrExc  = writeEn;
      end
      IDX_ENA: begin
        strobes.rdView = VIEW_ENA;
        strobes.wrEna  = writeEn;
      end
      IDX_FULL: begin
        strobes.rdView = VIEW_FULL;
        strobes.wrFull = writeEn;
      end
      default: strobes.rdView = VIEW_NONE;
    endcase
  end

endmodule

// File: rtl/fpcsr_cause_map.sv
module fpcsr_cause_map
  import fpcsr_pkg::*;
#(
  parameter int NUM_INVALID = 8,
  localparam int STAT_W     = NUM_INVALID + 5
) (
  input  logic [STAT_W-1:0]  opStatus,
  output logic [CAUSE_W-1:0] newCause
);

  localparam int ST_DIVZ   = NUM_INVALID;
  localparam int ST_OVER   = NUM_INVALID + 1;
  localparam int ST_UNDER  = NUM_INVALID + 2;
  localparam int ST_INEX   = NUM_INVALID + 3;
  localparam int ST_UNIMPL = NUM_INVALID + 4;

  always_comb begin
    newCause             = '0;
    newCause[CB_INVALID] = |opStatus[NUM_INVALID-1:0];
    newCause[CB_DIVZ]    = opStatus[ST_DIVZ];
    newCause[CB_OVER]    = opStatus[ST_OVER];
    newCause[CB_UNDER]   = opStatus[ST_UNDER];
    newCause[CB_INEXACT] = opStatus[ST_INEX];
    newCause[CB_UNIMPL]  = opStatus[ST_UNIMPL];
  end

endmodule

// File: rtl/fpcsr_datapath.sv
module fpcsr_datapath
  import fpcsr_pkg::*;
#(
  parameter logic [WORD_W-1:0] IMPL_REV = 32'h0000_A512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       strobes,
  input  logic [WORD_W-1:0]  writeData,
  input  logic               opDone,
  input  logic [CAUSE_W-1:0] newCause,
  output logic [WORD_W-1:0]  csrWord,
  output logic [WORD_W-1:0]  readData,
  output logic               trapReq
);

  logic [WORD_W-1:0] afterSw;
  logic [WORD_W-1:0] nextWord;
  logic [EXC_W-1:0]  flagsNext;
  logic              trapNext;

  // software view writes, applied before the operation update
  always_comb begin
    afterSw = csrWord;
    if (strobes.wrCc) begin
      afterSw[CC0_BIT]                = writeData[0];
      afterSw[CCHI_LSB +: CCHI_W]     = writeData[CC_VIEW_W-1:1];
    end
    if (strobes.wrExc) begin
      afterSw = (afterSw & ~EXC_VIEW_MASK) | (writeData & EXC_VIEW_MASK);
    end
    if (strobes.wrEna) begin
      afterSw          = (afterSw & ENA_KEEP_MASK) | (writeData & ENA_VIEW_MASK);
      afterSw[FTZ_BIT] = writeData[ENA_FTZ_ALT] | writeData[FTZ_BIT];
    end
    if (strobes.wrFull) begin
      afterSw = writeData & ~RSV_MASK;
    end
  end

  // sticky flags accumulate cause bits other than unimplemented
  for (genvar k = 0; k < EXC_W; k++) begin : g_sticky
    assign flagsNext[k] = afterSw[FLAG_LSB + k] | (opDone & newCause[k]);
  end

  always_comb begin
    nextWord = afterSw;
    if (opDone) begin
      nextWord[CAUSE_LSB +: CAUSE_W] = newCause;
    end
    nextWord[FLAG_LSB +: EXC_W] = flagsNext;
    nextWord = nextWord & ~RSV_MASK;
  end

  assign trapNext = opDone
                  & ((|(newCause[EXC_W-1:0] & afterSw[ENA_LSB +: EXC_W]))
                     | newCause[CB_UNIMPL]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csrWord <= '0;
      trapReq <= 1'b0;
    end else begin
      csrWord <= nextWord;
      trapReq <= trapNext;
    end
  end

  // read views
  always_comb begin
    readData = '0;
    unique case (strobes.rdView)
      VIEW_ID:   readData = IMPL_REV;
      VIEW_CC:   readData = WORD_W'({csrWord[CCHI_LSB +: CCHI_W], csrWord[CC0_BIT]});
      VIEW_EXC:  readData = csrWord & EXC_VIEW_MASK;
      VIEW_ENA:  readData = (csrWord & ENA_VIEW_MASK)
                          | (WORD_W'(csrWord[FTZ_BIT]) << ENA_FTZ_ALT);
      VIEW_FULL: readData = csrWord & ~RSV_MASK;
      default:   readData = '0;
    endcase
  end

endmodule

// File: rtl/fp_ctrl_reg_unit.sv
module fp_ctrl_reg_unit
  import fpcsr_pkg::*;
#(
  parameter int                NUM_INVALID = 8,
  parameter logic [WORD_W-1:0] IMPL_REV    = 32'h0000_A512,
  localparam int               STAT_W      = NUM_INVALID + 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] index,
  input  logic [WORD_W-1:0]  writeData,
  input  logic               writeEn,
  output logic [WORD_W-1:0]  readData,
  input  logic               opDone,
  input  logic [STAT_W-1:0]  opStatus,
  output logic               trapReq,
  output logic [RM_W-1:0]    roundMode,
  output logic               flushZero
);

  ctrlStrobes_t       strobes;
  logic [CAUSE_W-1:0] newCause;
  logic [WORD_W-1:0]  csrWord;

  fpcsr_ctrl ctrl_i (
    .index   (index),
    .writeEn (writeEn),
    .strobes (strobes)
  );

  fpcsr_cause_map #(.NUM_INVALID(NUM_INVALID)) cmap_i (
    .opStatus (opStatus),
    .newCause (newCause)
  );

  fpcsr_datapath #(.IMPL_REV(IMPL_REV)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .writeData (writeData),
    .opDone    (opDone),
    .newCause  (newCause),
    .csrWord   (csrWord),
    .readData  (readData),
    .trapReq   (trapReq)
  );

  assign roundMode = csrWord[RM_LSB +: RM_W];
  assign flushZero = csrWord[FTZ_BIT];

endmodule

// File: rtl/fpcsr_checker.sv
module fpcsr_checker
  import fpcsr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               writeEn,
  input logic [INDEX_W-1:0] index,
  input logic [7:0]         ccData,
  input logic               opDone,
  input logic               opUnimpl,
  input logic [WORD_W-1:0]  csrWord,
  input logic               trapReq
);

  logic knownIdx;
  assign knownIdx = (index == IDX_CC) || (index == IDX_EXC)
                 || (index == IDX_ENA) || (index == IDX_FULL);

  // R11
  trap_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !opDone |=> !trapReq);

  // R11
  unimpl_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opDone && opUnimpl |=> trapReq);

  // R8
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(csrWord & RSV_MASK) == 0);

  // R2 R13
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    writeEn && !opDone && !knownIdx |=> $stable(csrWord));

  // R4
  cc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    writeEn && !opDone && index == IDX_CC |=>
      csrWord[CC0_BIT] == $past(ccData[0])
      && csrWord[CCHI_LSB +: CCHI_W] == $past(ccData[CC_VIEW_W-1:1]));

  // R10
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !writeEn |=> (csrWord & $past(csrWord) & FLAG_MASK) == ($past(csrWord) & FLAG_MASK));

endmodule

bind fp_ctrl_reg_unit fpcsr_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .writeEn  (writeEn),
  .index    (index),
  .ccData   (writeData[7:0]),
  .opDone   (opDone),
  .opUnimpl (opStatus[STAT_W-1]),
  .csrWord  (csrWord),
  .trapReq  (trapReq)
);

// File: tb/fp_ctrl_reg_unit_tb_top.sv
`timescale 1ns/1ps
module fp_ctrl_reg_unit_tb_top;

  localparam int          NINV = 8;
  localparam int          SW   = NINV + 5;
  localparam logic [31:0] REV  = 32'h0000_A512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  index = 5'h1F;
  logic [31:0] writeData = '0;
  logic        writeEn = 1'b0;
  logic [31:0] readData;
  logic        opDone = 1'b0;
  logic [SW-1:0] opStatus = '0;
  logic        trapReq;
  logic [1:0]  roundMode;
  logic        flushZero;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] model = '0;
  bit          expTrap = 1'b0;

  always #4 clk = ~clk;

  fp_ctrl_reg_unit #(.NUM_INVALID(NINV), .IMPL_REV(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .index(index), .writeData(writeData),
    .writeEn(writeEn), .readData(readData), .opDone(opDone),
    .opStatus(opStatus), .trapReq(trapReq), .roundMode(roundMode),
    .flushZero(flushZero)
  );

  // reference model from the requirements
  function automatic logic [31:0] mRead(logic [4:0] idx, logic [31:0] w);
    case (idx)
      5'h00: return REV;
      5'h19: return {24'h0, w[31:25], w[23]};
      5'h1A: return w & 32'h0003_F07C;
      5'h1C: return (w & 32'h0000_0F83) | (w[24] ? 32'h4 : 32'h0);
      5'h1F: return w & ~32'h007C_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mWrite(logic [31:0] w, logic [4:0] idx, logic [31:0] v);
    logic [31:0] r;
    r = w;
    case (idx)
      5'h19: begin r[31:25] = v[7:1]; r[23] = v[0]; end
      5'h1A: r = (w & ~32'h0003_F07C) | (v & 32'h0003_F07C);
      5'h1C: begin
        r = (w & 32'hFF83_F07C) | (v & 32'h0000_0F83);
        r[24] = v[2] | v[24];
      end
      5'h1F: r = v & ~32'h007C_0000;
      default: r = w;
    endcase
    return r;
  endfunction

  function automatic logic [5:0] mCause(logic [SW-1:0] st);
    return {st[NINV+4], |st[NINV-1:0], st[NINV], st[NINV+1], st[NINV+2], st[NINV+3]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit we, logic [4:0] idx, logic [31:0] wd, bit op, logic [SW-1:0] st);
    logic [5:0] c;
    @(negedge clk);
    writeEn = we; index = idx; writeData = wd; opDone = op; opStatus = st;
    @(posedge clk);
    if (we) model = mWrite(model, idx, wd);
    expTrap = 1'b0;
    if (op) begin
      c = mCause(st);
      expTrap = (|(c[4:0] & model[11:7])) | c[5];
      model[17:12] = c;
      model[6:2]   = model[6:2] | c[4:0];
    end
    #1;
    writeEn = 1'b0; opDone = 1'b0;
  endtask

  // checks trap from the last step, then full view and exported controls
  task automatic verify(string req);
    @(negedge clk);
    chk({req, " trap R11"}, 32'(trapReq), 32'(expTrap));
    index = 5'h1F;
    #1;
    chk({req, " full"}, readData, mRead(5'h1F, model));
    chk({req, " ctl R12"}, {29'h0, flushZero, roundMode}, {29'h0, model[24], model[1:0]});
  endtask

  task automatic readView(string req, logic [4:0] idx);
    @(negedge clk);
    index = idx;
    #1;
    chk(req, readData, mRead(idx, model));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] st;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    verify("R1");
    readView("R1 full", 5'h1F);

    // R2 identity read, ignored write
    readView("R2 id", 5'h00);
    step(1'b1, 5'h00, 32'hFFFF_FFFF, 1'b0, '0);
    verify("R2 ignored");

    // R8 full write drops reserved bits, R12 exports
    step(1'b1, 5'h1F, 32'hFFFF_FFFF, 1'b0, '0);
    verify("R8");
    chk("R8 value", readData, 32'hFF83_FFFF);

    // R3 / R4 condition-code view
    readView("R3 cc", 5'h19);
    step(1'b1, 5'h19, 32'h0000_005A, 1'b0, '0);
    verify("R4");
    readView("R3 cc after", 5'h19);
    chk("R4 ftz untouched", 32'(flushZero), 32'd1);

    // R5 exception view
    readView("R5 exc", 5'h1A);
    step(1'b1, 5'h1A, 32'h0000_0000, 1'b0, '0);
    verify("R5");
    readView("R5 exc cleared", 5'h1A);

    // R6 / R7 enables view
    readView("R6 ena ftz", 5'h1C);
    step(1'b1, 5'h1C, 32'h0000_0004, 1'b0, '0);
    verify("R7 alt ftz");
    step(1'b1, 5'h1C, 32'h0000_0000, 1'b0, '0);
    verify("R7 cleared");
    readView("R6 ena no ftz", 5'h1C);
    step(1'b1, 5'h1C, 32'h0100_0082, 1'b0, '0);
    verify("R7 ftz bit24");

    // R9 / R10 / R11 operation updates
    step(1'b0, 5'h1F, 32'h0, 1'b1, SW'(1) << (NINV + 4));
    verify("R10 unimpl no flag");
    step(1'b0, 5'h1F, 32'h0, 1'b1, SW'(1) << (NINV + 3));
    verify("R11 enabled inexact");
    step(1'b0, 5'h1F, 32'h0, 1'b1, SW'(1) << (NINV + 1));
    verify("R11 disabled overflow");
    for (int k = 0; k < NINV; k++) begin
      step(1'b0, 5'h1F, 32'h0, 1'b1, SW'(1) << k);
      verify("R9 invalid kind");
    end
    step(1'b0, 5'h1F, 32'h0, 1'b1, '0);
    verify("R9 empty status");

    // R13 unlisted index
    step(1'b1, 5'h05, 32'hFFFF_FFFF, 1'b0, '0);
    verify("R13 write");
    readView("R13 read", 5'h05);

    // R14 write and operation in one cycle
    step(1'b1, 5'h1C, 32'h0000_0100, 1'b1, SW'(1) << (NINV + 2));
    verify("R14 ena then op");
    step(1'b1, 5'h1A, 32'h0003_F07C, 1'b1, SW'(1) << (NINV + 3));
    verify("R14 exc then op");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [4:0] idxs [6];
      logic [4:0] ri;
      idxs = '{5'h00, 5'h19, 5'h1A, 5'h1C, 5'h1F, 5'h0B};
      ri = idxs[$urandom_range(0, 5)];
      st = SW'($urandom);
      if ($urandom_range(0, 3) == 0) st = '0;
      if ($urandom_range(0, 2) != 0) st[NINV+4] = 1'b0;
      step(1'($urandom), ri, $urandom, 1'($urandom), st);
      verify("R9 R10 R14 random");
      readView("R3 R5 R6 random view", idxs[$urandom_range(0, 5)]);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule